// File: doc/BRIEF.md
# Interrupt Claim/Complete Register Block

This block is the software-visible half of a platform interrupt controller. Level-sensitive source lines come in and one interrupt line per target context goes out. A 32-bit register bus gives access to the following state:

- a priority for every source;
- a read-only word of pending bits;
- an enable word for each context;
- a threshold for each context;
- a claim/complete register for each context.

Each context has a selector. It picks, among the sources that are pending, enabled for that context and not yet claimed, the one whose priority is highest and strictly above the context's threshold.

Software handles an interrupt in two steps. It reads the context's claim register, which returns the winning source number. The same access clears that source's pending bit and marks the source as claimed, so that no context can select it. When service is done, software writes the source number back to the same register to release it.

The bus side is a two-state machine:

- `BUS_IDLE` holds `req_ready` high.
- The transition `IDLE_TO_RESP` fires when `req_valid` is seen in `BUS_IDLE`. It moves to `BUS_RESP`, which presents `rsp_valid` with the registered read data for one cycle.
- The transition `RESP_TO_IDLE` returns to `BUS_IDLE` unconditionally.
- `IDLE_HOLD` keeps the machine in `BUS_IDLE` while no request arrives.

Every base address and stride is a parameter.

Top module: `irqc_regfile`

## Requirements
- R1: After reset, every priority, threshold, enable bit, pending bit and claimed bit is zero. Every `irq_o` bit is low, `req_ready` is high and `rsp_valid` is low.
- R2: The priority of source n is at address PRIO_BASE + 4·n. When PRIO_MAX+1 is a power of two, a write stores the value modulo PRIO_MAX+1, and a read returns the stored value. With the default PRIO_MAX of 7, writing 13 reads back 5.
- R3: When PRIO_MAX+1 is not a power of two, a priority or threshold write whose value exceeds PRIO_MAX is discarded and the old value is kept. A legal value is stored as written.
- R4: Bit n of the pending word at PEND_BASE follows the level of `src_i[n]` one cycle later. Bit 0 always reads 0. Writes to the pending word have no effect.
- R5: Context c has its enable word 0 at EN_BASE + c·EN_STRIDE. Bit n enables source n, and bits at or above NUM_SRC read 0. Enable words at or beyond the number of 32-bit bitfield words read 0 and ignore writes.
- R6: The threshold of context c is at offset 0 of its context area, CTX_BASE + c·CTX_STRIDE. It follows the same legalisation rule as priorities.
- R7: A source is a candidate for context c when it is pending, enabled in c, not claimed, and its priority is strictly greater than c's threshold. `irq_o[c]` is high exactly when c has a candidate. A read of the claim register (offset 4) returns the candidate with the highest priority, the lowest source number winning a tie, or 0 when there is no candidate.
- R8: A claim read that returns a nonzero source clears that source's pending bit in the same cycle, even if the source line is high. It also sets the source's claimed bit, so that no context selects it until it is completed. From the next cycle on, the pending bit follows the line again.
- R9: A write of value v to any context's claim register clears the claimed bit of source v when v < NUM_SRC. A larger value changes nothing.
- R10: A read of an unmapped address, or of a context offset other than 0 or 4, returns 0. A write to such an address changes no state.
- R11: An access is accepted when `req_valid` and `req_ready` are both high. In the next cycle `rsp_valid` is high for exactly one cycle and `req_ready` is low. For a read, `rsp_rdata` carries the read data; for a write it carries 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt source lines, bit 0 unused |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response cycle for the access accepted one cycle earlier |
| rsp_rdata | output | 32 | Read data of that access |
| irq_o | output | NUM_CTX | External interrupt line per context |

## Verification
The assertions assume that every access uses a word-aligned address, and that a requester holds back a new request while the block is in its response cycle. The stimulus keeps to these limits: it drives only aligned addresses, issues one access at a time, and waits for the response before raising `req_valid` again. The assertions further assume that the claim and complete paths never act in the same cycle. The single-request bus guarantees this, because one access is either a read or a write. Source lines change only between bus accesses, so every line level and every access outcome can be observed in a known cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PRIO,
        ACC_PEND,
        ACC_EN,
        ACC_THR,
        ACC_CLAIM
    } acc_kind_t;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_t;

    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input logic [31:0] span);
        return (a >= base) && ((a - base) < span);
    endfunction

endpackage

// File: rtl/irqc_bus_fsm.sv
module irqc_bus_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic rsp_valid,
    output logic accept
);

    bus_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_valid) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            BUS_IDLE: req_ready = 1'b1;
            BUS_RESP: rsp_valid = 1'b1;
        endcase
        accept = req_ready && req_valid;
    end

endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
    parameter int NUM_SRC = 8,
    parameter int PW      = 3,
    parameter int IDW     = 3
) (
    input  logic [NUM_SRC-1:0]    cand,
    input  logic [NUM_SRC*PW-1:0] prio_flat,
    input  logic [PW-1:0]         thresh,
    output logic [IDW-1:0]        win_id,
    output logic                  win_valid
);

    logic [PW-1:0] best;

    always_comb begin
        best   = thresh;
        win_id = '0;
        for (int i = 1; i < NUM_SRC; i++) begin
            if (cand[i] && (prio_flat[i*PW +: PW] > best)) begin
                best   = prio_flat[i*PW +: PW];
                win_id = IDW'(i);
            end
        end
        win_valid = (win_id != '0);
    end

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int          NUM_SRC    = 8,
    parameter int          NUM_CTX    = 2,
    parameter int          PRIO_MAX   = 7,
    parameter int          ADDR_W     = 16,
    parameter int unsigned PRIO_BASE  = 32'h0000,
    parameter int unsigned PEND_BASE  = 32'h1000,
    parameter int unsigned EN_BASE    = 32'h2000,
    parameter int unsigned EN_STRIDE  = 32'h0080,
    parameter int unsigned CTX_BASE   = 32'h4000,
    parameter int unsigned CTX_STRIDE = 32'h1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [NUM_CTX-1:0] irq_o
);

    localparam int  EN_WORDS = (NUM_SRC + 31) / 32;
    localparam int  PADW     = EN_WORDS * 32;
    localparam int  PW       = (PRIO_MAX < 1) ? 1 : $clog2(PRIO_MAX + 1);
    localparam int  IDW      = (NUM_SRC < 2) ? 1 : $clog2(NUM_SRC);
    localparam int  CW       = (NUM_CTX < 2) ? 1 : $clog2(NUM_CTX);
    localparam int  WW       = (EN_WORDS < 2) ? 1 : $clog2(EN_WORDS);
    localparam bit  WRAP     = (((PRIO_MAX + 1) & PRIO_MAX) == 0);

    logic                acc_go;
    logic [PW-1:0]       prio_q [NUM_SRC];
    logic [PW-1:0]       thr_q  [NUM_CTX];
    logic [NUM_SRC-1:0]  en_q   [NUM_CTX];
    logic [NUM_SRC-1:0]  pend_q, clm_q;
    logic [31:0]         rdata_q;

    logic [NUM_SRC*PW-1:0]         prio_flat;
    logic [NUM_CTX-1:0][IDW-1:0]   win_id;
    logic [NUM_CTX-1:0]            win_valid;

    acc_kind_t    kind;
    logic [31:0]  a, off;
    logic [IDW-1:0] src_sel;
    logic [CW-1:0]  ctx_sel;
    logic [WW-1:0]  word_sel;
    logic [PADW-1:0] pend_pad, en_pad, en_wr;
    logic [31:0]  rd_val;
    logic         val_ok;
    logic [PW-1:0] val_leg;
    logic         claim_go, done_try, done_go;
    logic [IDW-1:0] claim_id, done_id;

    irqc_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .accept    (acc_go)
    );

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_flat
            assign prio_flat[s*PW +: PW] = prio_q[s];
        end
        for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
            irqc_select #(.NUM_SRC(NUM_SRC), .PW(PW), .IDW(IDW)) u_sel (
                .cand      (pend_q & en_q[c] & ~clm_q),
                .prio_flat (prio_flat),
                .thresh    (thr_q[c]),
                .win_id    (win_id[c]),
                .win_valid (win_valid[c])
            );
        end
    endgenerate

    assign irq_o     = win_valid;
    assign rsp_rdata = rdata_q;

    // address decode
    always_comb begin
        a        = 32'(req_addr);
        kind     = ACC_NONE;
        off      = '0;
        src_sel  = '0;
        ctx_sel  = '0;
        word_sel = '0;
        if (in_window(a, PRIO_BASE, 32'(NUM_SRC * 4))) begin
            kind    = ACC_PRIO;
            src_sel = IDW'((a - PRIO_BASE) >> 2);
        end else if (in_window(a, PEND_BASE, 32'(EN_WORDS * 4))) begin
            kind     = ACC_PEND;
            word_sel = WW'((a - PEND_BASE) >> 2);
        end else if (in_window(a, EN_BASE, 32'(NUM_CTX) * EN_STRIDE)) begin
            ctx_sel = CW'((a - EN_BASE) / EN_STRIDE);
            off     = ((a - EN_BASE) & (EN_STRIDE - 1)) >> 2;
            if (off < 32'(EN_WORDS)) begin
                kind     = ACC_EN;
                word_sel = WW'(off);
            end
        end else if (in_window(a, CTX_BASE, 32'(NUM_CTX) * CTX_STRIDE)) begin
            ctx_sel = CW'((a - CTX_BASE) / CTX_STRIDE);
            off     = (a - CTX_BASE) & (CTX_STRIDE - 1);
            if (off == 32'd0)      kind = ACC_THR;
            else if (off == 32'd4) kind = ACC_CLAIM;
        end
    end

    // legalisation of priority/threshold values
    always_comb begin
        val_ok  = WRAP || (req_wdata <= 32'(PRIO_MAX));
        val_leg = WRAP ? PW'(req_wdata & 32'(PRIO_MAX)) : PW'(req_wdata);
    end

    always_comb begin
        pend_pad                    = '0;
        pend_pad[NUM_SRC-1:0]       = pend_q;
        en_pad                      = '0;
        en_pad[NUM_SRC-1:0]         = en_q[ctx_sel];
        en_wr                       = en_pad;
        en_wr[int'(word_sel)*32 +: 32] = req_wdata;

        claim_go = acc_go && !req_write && (kind == ACC_CLAIM) && win_valid[ctx_sel];
        claim_id = win_id[ctx_sel];
        done_try = acc_go && req_write && (kind == ACC_CLAIM);
        done_go  = done_try && (req_wdata < 32'(NUM_SRC));
        done_id  = IDW'(req_wdata);

        unique case (kind)
            ACC_PRIO:  rd_val = 32'(prio_q[src_sel]);
            ACC_PEND:  rd_val = pend_pad[int'(word_sel)*32 +: 32];
            ACC_EN:    rd_val = en_pad[int'(word_sel)*32 +: 32];
            ACC_THR:   rd_val = 32'(thr_q[ctx_sel]);
            ACC_CLAIM: rd_val = 32'(win_id[ctx_sel]);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
            for (int c = 0; c < NUM_CTX; c++) begin
                thr_q[c] <= '0;
                en_q[c]  <= '0;
            end
            pend_q  <= '0;
            clm_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (acc_go) rdata_q <= req_write ? 32'd0 : rd_val;
            if (acc_go && req_write) begin
                if (kind == ACC_PRIO && val_ok) prio_q[src_sel] <= val_leg;
                if (kind == ACC_THR  && val_ok) thr_q[ctx_sel]  <= val_leg;
                if (kind == ACC_EN)             en_q[ctx_sel]   <= en_wr[NUM_SRC-1:0];
            end
            for (int i = 0; i < NUM_SRC; i++) begin
                pend_q[i] <= (i != 0) && src_i[i] && !(claim_go && claim_id == IDW'(i));
                if (claim_go && claim_id == IDW'(i))     clm_q[i] <= 1'b1;
                else if (done_go && done_id == IDW'(i))  clm_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_SRC = 8,
    parameter int NUM_CTX = 2,
    parameter int IDW     = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_ready,
    input logic                        rsp_valid,
    input logic [31:0]                 req_wdata,
    input logic                        acc_go,
    input logic                        claim_go,
    input logic [IDW-1:0]              claim_id,
    input logic                        done_try,
    input logic [NUM_SRC-1:0]          pend_q,
    input logic [NUM_SRC-1:0]          clm_q,
    input logic [NUM_CTX-1:0][IDW-1:0] win_id
);

    AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |=> (rsp_valid && !req_ready)); // R11

    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11

    AST_CLAIM_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        claim_go |=> (!pend_q[$past(claim_id)] && clm_q[$past(claim_id)])); // R8

    AST_BAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_try && (req_wdata >= 32'(NUM_SRC))) |=> $stable(clm_q)); // R9

    AST_SRC0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0] && !clm_q[0]); // R4

    generate
        for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
            AST_WIN_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
                (win_id[c] != '0) |-> !clm_q[win_id[c]]); // R7
        end
    endgenerate

endmodule

bind irqc_regfile irqc_checker #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .IDW     (IDW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .req_wdata (req_wdata),
    .acc_go    (acc_go),
    .claim_go  (claim_go),
    .claim_id  (claim_id),
    .done_try  (done_try),
    .pend_q    (pend_q),
    .clm_q     (clm_q),
    .win_id    (win_id)
);

// File: tb/irqc_regfile_bench.sv
`timescale 1ns/1ps
module irqc_regfile_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [7:0]  src = '0;
    logic        m_valid = 0, m_write = 0, a_valid = 0, a_write = 0;
    logic [15:0] m_addr = '0, a_addr = '0;
    logic [31:0] m_wdata = '0, a_wdata = '0;
    logic        m_ready, m_rv, a_ready, a_rv;
    logic [31:0] m_rdata, a_rdata;
    logic [1:0]  m_irq, a_irq;
    logic        last_rv, last_rdy;

    int checks = 0;
    int fails  = 0;

    irqc_regfile u_irqc_regfile (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .req_valid(m_valid), .req_write(m_write), .req_addr(m_addr), .req_wdata(m_wdata),
        .req_ready(m_ready), .rsp_valid(m_rv), .rsp_rdata(m_rdata), .irq_o(m_irq));

    irqc_regfile #(.PRIO_MAX(5)) u_irqc_regfile_alt (
        .clk(clk), .rst_n(rst_n), .src_i(8'h00),
        .req_valid(a_valid), .req_write(a_write), .req_addr(a_addr), .req_wdata(a_wdata),
        .req_ready(a_ready), .rsp_valid(a_rv), .rsp_rdata(a_rdata), .irq_o(a_irq));

    localparam logic [15:0] PEND = 16'h1000, EN0 = 16'h2000, EN1 = 16'h2080;
    localparam logic [15:0] THR0 = 16'h4000, CLM0 = 16'h4004, THR1 = 16'h5000, CLM1 = 16'h5004;

    // {write, addr, wdata, expected read}
    localparam int NV = 22;
    localparam logic [80:0] VEC [NV] = '{
        {1'b1, 16'h000C, 32'd5,          32'd0},
        {1'b0, 16'h000C, 32'd0,          32'd5},
        {1'b1, 16'h0014, 32'd13,         32'd0},
        {1'b0, 16'h0014, 32'd0,          32'd5},
        {1'b1, 16'h0018, 32'd7,          32'd0},
        {1'b0, 16'h0018, 32'd0,          32'd7},
        {1'b1, EN0,      32'hFFFF_FFFF,  32'd0},
        {1'b0, EN0,      32'd0,          32'h0000_00FF},
        {1'b1, 16'h2004, 32'h55,         32'd0},
        {1'b0, 16'h2004, 32'd0,          32'd0},
        {1'b1, THR0,     32'd10,         32'd0},
        {1'b0, THR0,     32'd0,          32'd2},
        {1'b1, PEND,     32'hFF,         32'd0},
        {1'b0, PEND,     32'd0,          32'd0},
        {1'b0, 16'h0800, 32'd0,          32'd0},
        {1'b1, 16'h4008, 32'd3,          32'd0},
        {1'b0, 16'h4008, 32'd0,          32'd0},
        {1'b1, THR1,     32'd3,          32'd0},
        {1'b0, THR1,     32'd0,          32'd3},
        {1'b1, EN1,      32'h28,         32'd0},
        {1'b0, EN1,      32'd0,          32'h28},
        {1'b0, CLM0,     32'd0,          32'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input bit alt, input bit wr, input logic [15:0] addr,
                       input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        if (alt) begin a_valid = 1; a_write = wr; a_addr = addr; a_wdata = wd; end
        else     begin m_valid = 1; m_write = wr; m_addr = addr; m_wdata = wd; end
        @(negedge clk);
        rd       = alt ? a_rdata : m_rdata;
        last_rv  = alt ? a_rv : m_rv;
        last_rdy = alt ? a_ready : m_ready;
        a_valid = 0;
        m_valid = 0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq after reset", 32'(m_irq), 32'd0);
        chk("R1 ready after reset", 32'(m_ready), 32'd1);
        chk("R1 rsp_valid after reset", 32'(m_rv), 32'd0);
        bus(0, 0, 16'h000C, 0, rd); chk("R1 priority after reset", rd, 0);
        bus(0, 0, THR0, 0, rd);     chk("R1 threshold after reset", rd, 0);
        bus(0, 0, EN0, 0, rd);      chk("R1 enable after reset", rd, 0);
        chk("R11 rsp_valid in response cycle", 32'(last_rv), 32'd1);
        chk("R11 ready low in response cycle", 32'(last_rdy), 32'd0);

        // table walk: R2 R4 R5 R6 R10 R7
        for (int k = 0; k < NV; k++) begin
            bus(0, VEC[k][80], VEC[k][79:64], VEC[k][63:32], rd);
            if (!VEC[k][80]) chk($sformatf("table entry %0d (R2 R4 R5 R6 R7 R10)", k), rd, VEC[k][31:0]);
        end

        // sources 0,3,5,6 high
        src = 8'h69;
        repeat (2) @(negedge clk);
        chk("R7 both contexts requesting", 32'(m_irq), 32'd3);
        bus(0, 0, PEND, 0, rd); chk("R4 pending mirrors lines, bit0 zero", rd, 32'h68);
        bus(0, 0, CLM0, 0, rd); chk("R7 highest priority wins", rd, 6);
        bus(0, 0, CLM0, 0, rd); chk("R7 tie goes to lowest id", rd, 3);
        bus(0, 0, CLM1, 0, rd); chk("R8 claimed source hidden from other context", rd, 5);
        chk("R8 all claimed, no request", 32'(m_irq), 32'd0);
        bus(0, 0, CLM0, 0, rd); chk("R7 no candidate reads zero", rd, 0);
        bus(0, 0, PEND, 0, rd); chk("R8 pending follows high lines again", rd, 32'h68);

        bus(0, 1, CLM0, 8, rd); chk("R9 out of range complete ignored", 32'(m_irq), 32'd0);
        bus(0, 1, CLM0, 6, rd); chk("R9 complete releases source", 32'(m_irq), 32'd1);
        bus(0, 0, CLM1, 0, rd); chk("R7 source not enabled in ctx1", rd, 0);
        bus(0, 0, CLM0, 0, rd); chk("R8 re-claim after complete", rd, 6);
        bus(0, 1, CLM1, 5, rd);
        bus(0, 1, CLM0, 3, rd); chk("R9 complete through any context", 32'(m_irq), 32'd3);
        bus(0, 1, THR1, 5, rd); chk("R7 equal priority below threshold", 32'(m_irq), 32'd1);
        bus(0, 1, THR1, 4, rd); chk("R6 lower threshold re-enables", 32'(m_irq), 32'd3);

        src = 8'h00;
        repeat (2) @(negedge clk);
        chk("R4 low lines clear requests", 32'(m_irq), 32'd0);
        bus(0, 0, PEND, 0, rd); chk("R4 pending cleared by low lines", rd, 0);

        // R3 discard mode on the PRIO_MAX=5 instance
        bus(1, 1, 16'h0008, 9, rd);
        bus(1, 0, 16'h0008, 0, rd); chk("R3 illegal priority discarded", rd, 0);
        bus(1, 1, 16'h0008, 4, rd);
        bus(1, 0, 16'h0008, 0, rd); chk("R3 legal priority stored", rd, 4);
        bus(1, 1, 16'h0008, 6, rd);
        bus(1, 0, 16'h0008, 0, rd); chk("R3 illegal priority keeps old value", rd, 4);
        bus(1, 1, THR0, 7, rd);
        bus(1, 0, THR0, 0, rd); chk("R3 illegal threshold discarded", rd, 0);
        bus(1, 1, THR0, 5, rd);
        bus(1, 0, THR0, 0, rd); chk("R3 maximum threshold stored", rd, 5);

        summary();
        $finish;
    end

endmodule